// File: doc/BRIEF.md
# Bus-Cycle-Counting Processor Clock Stop Controller

This block sits beside a processor with an asynchronous, strobe-based bus. It puts the processor into a static low-power state by gating off its clock at an exact bus-cycle boundary. Software starts the sequence with a supervisor data write to a chosen low-power address, and then executes a stop instruction. The controller recognises that write and counts the bus cycles that follow it. When the cycles that fetch the stop instruction's immediate operand have ended, it holds the processor clock low.

The number of fetch cycles depends on the data bus width. A 16-bit bus needs one fetch cycle and an 8-bit bus needs two, so a static mode input selects the count. The gated clock is the free-running system clock ANDed with an enable that changes only while the system clock is low. Every high phase that reaches the processor therefore has full width. A restart input or a reset returns the block to idle and lets the clock run again.

Top module: `lpc_clk_stop`

## Requirements
- R1: A bus cycle is a match when `addr` equals the parameter `LP_ADDR`, `rw_n` is 0 (write) and `fc` is 3'b101 (supervisor data). These inputs are sampled at the `sys_clk` rising edge that first sees `as_n` low. A read, any other `fc` value, or any other address is not a match.
- R2: The comparison covers all 24 address bits, so a change in any single bit of `addr` prevents a match.
- R3: Each high-to-low transition of `as_n` counts as one bus cycle. The matching write is itself the first counted cycle. Writes that do not match leave the block idle, and later cycles do not stop the clock.
- R4: With `bus8` = 0 (16-bit bus), the clock stops after exactly one bus cycle that follows the matching write.
- R5: With `bus8` = 1 (8-bit bus), the clock stops after exactly two bus cycles that follow the matching write. It does not stop after only one.
- R6: Suppose the last counted cycle ends with `as_n` sampled high at rising edge k of `sys_clk`. The processor clock is then disabled at the next falling edge of `sys_clk`. The high phase that starts at edge k is still delivered, and `stopped` reads 1 from that falling edge on.
- R7: `cpu_clk` carries only full half-period high phases, when stopping and when restarting. It is low whenever `stopped` is 1.
- R8: `restart` is sampled at a `sys_clk` rising edge and clears the count and the stopped state. The clock resumes at the next falling edge, and later cycles need a new matching write.
- R9: An asserted `rst` clears the count and the stopped state at once, without waiting for a clock edge. `cpu_clk` then follows `sys_clk`.
- R10: A matching write that arrives while a count is in progress counts as an ordinary cycle and does not restart the count.
- R11: Once set, `stopped` stays 1 and `cpu_clk` stays low until `restart` or `rst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | Free-running system clock |
| rst | input | 1 | Asynchronous reset, active high |
| restart | input | 1 | Synchronous wake request, active high |
| addr | input | 24 | Processor address bus |
| rw_n | input | 1 | Read (1) / write (0) |
| fc | input | 3 | Processor function code |
| as_n | input | 1 | Address strobe, active low |
| bus8 | input | 1 | Static data bus width select: 1 = 8-bit, 0 = 16-bit |
| cpu_clk | output | 1 | Gated processor clock |
| stopped | output | 1 | High while the processor clock is held off |

## Verification
The bench sweeps every function code, flips each of the 24 address bits in turn and tries a read at the low-power address. Each of these must leave the clock running; a comparator that ignored a field would stop the clock. In both bus modes it checks the stop edge to the exact half cycle. An off-by-one stage count would stop a fetch cycle early or late, and a register too many in the enable path would let one extra high phase through. It also sends a second matching write in the middle of a count, and a design that restarted its count on that write would fail to stop. It issues restart and reset while stopped or mid-count, and a cleared state that lingered would stop the clock on later, unrelated cycles. A monitor measures the width of every processor clock pulse, so gating outside the low phase shows up as a runt.

// File: rtl/lpc_pkg.sv
package lpc_pkg;

   // How the bus-cycle tracker stores its position
   typedef enum logic [0:0] {
      CNT_BINARY = 1'b0,
      CNT_ONEHOT = 1'b1
   } cnt_style_e;

   // Strobe events seen at a system clock rising edge
   typedef struct packed {
      logic start;   // strobe newly asserted: a bus cycle begins
      logic finish;  // strobe newly negated: a bus cycle ends
   } strobe_ev_t;

endpackage

// File: rtl/lpc_strobe_edge.sv
module lpc_strobe_edge (
   input  logic                sys_clk,
   input  logic                rst,
   input  logic                as_n,
   output lpc_pkg::strobe_ev_t ev
);
   logic as_q;

   always_ff @(posedge sys_clk or posedge rst) begin
      if (rst) as_q <= 1'b1;
      else     as_q <= as_n;
   end

   always_comb begin
      ev.start  = as_q & ~as_n;
      ev.finish = ~as_q & as_n;
   end
endmodule

// File: rtl/lpc_addr_match.sv
module lpc_addr_match #(
   parameter int            ADDR_W  = 24,
   parameter int            FC_W    = 3,
   parameter logic [ADDR_W-1:0] LP_ADDR = '0,
   parameter logic [FC_W-1:0]   SUP_FC  = '1
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              rw_n,
   input  logic [FC_W-1:0]   fc,
   output logic              hit
);
   logic addr_eq, fc_eq;

   always_comb begin
      addr_eq = (addr == LP_ADDR);
      fc_eq   = (fc == SUP_FC);
      hit     = addr_eq & fc_eq & ~rw_n;
   end
endmodule

// File: rtl/lpc_cycle_tracker.sv
module lpc_cycle_tracker #(
   parameter lpc_pkg::cnt_style_e STYLE = lpc_pkg::CNT_BINARY,
   parameter int CYC_WIDE   = 2,
   parameter int CYC_NARROW = 3,
   localparam int MAX_CYC   = (CYC_WIDE > CYC_NARROW) ? CYC_WIDE : CYC_NARROW,
   localparam int CNT_W     = $clog2(MAX_CYC + 1)
) (
   input  logic                sys_clk,
   input  logic                rst,
   input  logic                restart,
   input  lpc_pkg::strobe_ev_t ev,
   input  logic                hit,
   input  logic                bus8,
   output logic                stop_req
);
   if (STYLE == lpc_pkg::CNT_BINARY) begin : g_binary
      logic [CNT_W-1:0] cnt;
      logic [CNT_W-1:0] goal;

      assign goal = bus8 ? CNT_W'(CYC_NARROW) : CNT_W'(CYC_WIDE);

      always_ff @(posedge sys_clk or posedge rst) begin
         if (rst) begin
            cnt      <= '0;
            stop_req <= 1'b0;
         end else if (restart) begin
            cnt      <= '0;
            stop_req <= 1'b0;
         end else if (!stop_req) begin
            if (cnt == '0) begin
               if (ev.start && hit) cnt <= CNT_W'(1);
            end else if (cnt == goal) begin
               if (ev.finish) stop_req <= 1'b1;
            end else if (ev.start) begin
               cnt <= cnt + CNT_W'(1);
            end
         end
      end
   end else begin : g_onehot
      logic [MAX_CYC-1:0] stage;
      logic               at_goal;

      assign at_goal = bus8 ? stage[CYC_NARROW-1] : stage[CYC_WIDE-1];

      always_ff @(posedge sys_clk or posedge rst) begin
         if (rst) begin
            stage    <= '0;
            stop_req <= 1'b0;
         end else if (restart) begin
            stage    <= '0;
            stop_req <= 1'b0;
         end else if (!stop_req) begin
            if (stage == '0) begin
               if (ev.start && hit) stage <= MAX_CYC'(1);
            end else if (at_goal) begin
               if (ev.finish) stop_req <= 1'b1;
            end else if (ev.start) begin
               stage <= stage << 1;
            end
         end
      end
   end
endmodule

// File: rtl/lpc_clk_gate.sv
module lpc_clk_gate (
   input  logic sys_clk,
   input  logic rst,
   input  logic stop_req,
   output logic cpu_clk,
   output logic stopped
);
   logic run_q;

   // Enable and flag move only on the falling edge, i.e. while sys_clk is low
   always_ff @(negedge sys_clk or posedge rst) begin
      if (rst) begin
         run_q   <= 1'b1;
         stopped <= 1'b0;
      end else begin
         run_q   <= ~stop_req;
         stopped <= stop_req;
      end
   end

   assign cpu_clk = sys_clk & run_q;
endmodule

// File: rtl/lpc_clk_stop.sv
module lpc_clk_stop #(
   parameter int                  ADDR_W       = 24,
   parameter int                  FC_W         = 3,
   parameter logic [ADDR_W-1:0]   LP_ADDR      = 24'hFF_F000,
   parameter logic [FC_W-1:0]     SUP_FC       = 3'b101,
   parameter int                  FETCH_WIDE   = 1,
   parameter int                  FETCH_NARROW = 2,
   parameter lpc_pkg::cnt_style_e STYLE        = lpc_pkg::CNT_BINARY
) (
   input  logic              sys_clk,
   input  logic              rst,
   input  logic              restart,
   input  logic [ADDR_W-1:0] addr,
   input  logic              rw_n,
   input  logic [FC_W-1:0]   fc,
   input  logic              as_n,
   input  logic              bus8,
   output logic              cpu_clk,
   output logic              stopped
);
   // The matching write is counted in addition to the fetch cycles
   localparam int CYC_WIDE   = FETCH_WIDE + 1;
   localparam int CYC_NARROW = FETCH_NARROW + 1;

   if (ADDR_W < 1 || ADDR_W > 32) begin : g_bad_addr_w
      $error("lpc_clk_stop: ADDR_W out of range");
   end
   if (FC_W < 1) begin : g_bad_fc_w
      $error("lpc_clk_stop: FC_W must be positive");
   end
   if (FETCH_WIDE < 1 || FETCH_NARROW < 1) begin : g_bad_fetch
      $error("lpc_clk_stop: fetch cycle counts must be at least one");
   end

   lpc_pkg::strobe_ev_t ev;
   logic                hit;
   logic                stop_req;

   lpc_strobe_edge u_edge (
      .sys_clk (sys_clk),
      .rst     (rst),
      .as_n    (as_n),
      .ev      (ev)
   );

   lpc_addr_match #(
      .ADDR_W  (ADDR_W),
      .FC_W    (FC_W),
      .LP_ADDR (LP_ADDR),
      .SUP_FC  (SUP_FC)
   ) u_match (
      .addr (addr),
      .rw_n (rw_n),
      .fc   (fc),
      .hit  (hit)
   );

   lpc_cycle_tracker #(
      .STYLE      (STYLE),
      .CYC_WIDE   (CYC_WIDE),
      .CYC_NARROW (CYC_NARROW)
   ) u_track (
      .sys_clk  (sys_clk),
      .rst      (rst),
      .restart  (restart),
      .ev       (ev),
      .hit      (hit),
      .bus8     (bus8),
      .stop_req (stop_req)
   );

   lpc_clk_gate u_gate (
      .sys_clk  (sys_clk),
      .rst      (rst),
      .stop_req (stop_req),
      .cpu_clk  (cpu_clk),
      .stopped  (stopped)
   );
endmodule

// File: rtl/lpc_clk_stop_chk.sv
module lpc_clk_stop_chk (
   input logic sys_clk,
   input logic rst,
   input logic restart,
   input logic as_n,
   input logic cpu_clk,
   input logic stopped
);
   AST_STOPPED_CLK_LOW: assert property (@(negedge sys_clk) disable iff (rst)
      stopped |-> !cpu_clk); // R7

   AST_STOP_AFTER_STROBE_END: assert property (@(posedge sys_clk) disable iff (rst)
      $rose(stopped) |-> $past(as_n)); // R6

   AST_RESTART_WAKES: assert property (@(posedge sys_clk) disable iff (rst)
      restart |=> !stopped); // R8

   AST_STOPPED_HOLDS: assert property (@(posedge sys_clk) disable iff (rst)
      (stopped && !restart) |=> stopped); // R11
endmodule

bind lpc_clk_stop lpc_clk_stop_chk u_chk (
   .sys_clk (sys_clk),
   .rst     (rst),
   .restart (restart),
   .as_n    (as_n),
   .cpu_clk (cpu_clk),
   .stopped (stopped)
);

// File: tb/sim_lpc_clk_stop.sv
`timescale 1ns/1ps
module sim_lpc_clk_stop;
   localparam logic [23:0] LPA = 24'hA5_3C0E;

   logic        clk = 1'b0, rst = 1'b1, restart = 1'b0;
   logic        rw_n = 1'b1, as_n = 1'b1, bus8 = 1'b0;
   logic [23:0] addr = '0;
   logic [2:0]  fc = '0;
   logic        cpu_clk, stopped;
   int          checks = 0, errors = 0, bad_pulses = 0, pulses = 0;
   realtime     t_rise = 0.0;

   lpc_clk_stop #(.LP_ADDR(LPA)) u0 (
      .sys_clk(clk), .rst(rst), .restart(restart), .addr(addr), .rw_n(rw_n),
      .fc(fc), .as_n(as_n), .bus8(bus8), .cpu_clk(cpu_clk), .stopped(stopped));

   always #2 clk = ~clk;

   // Pulse-width monitor: each high phase of cpu_clk must last 2 ns
   always @(posedge cpu_clk) t_rise = $realtime;
   always @(negedge cpu_clk) begin
      pulses++;
      if (($realtime - t_rise) < 1.99 || ($realtime - t_rise) > 2.01) bad_pulses++;
   end

   task automatic summary();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   task automatic chk(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic bus_cyc(input logic [23:0] a, input logic rw, input logic [2:0] f);
      @(posedge clk); #1;
      addr = a; rw_n = rw; fc = f; as_n = 1'b0;
      repeat (2) @(posedge clk);
      #1 as_n = 1'b1;
   endtask

   // After a cycle ends: one more full high phase, then stopped == exp
   task automatic end_chk(input string req, input logic exp);
      @(posedge clk); #1;
      chk(req, stopped, 1'b0);
      chk(req, cpu_clk, 1'b1);
      @(posedge clk); #1;
      chk(req, stopped, exp);
      chk(req, cpu_clk, ~exp);
   endtask

   task automatic do_restart(input string req);
      @(posedge clk); #1 restart = 1'b1;
      @(posedge clk); #1 restart = 1'b0;
      @(posedge clk); #1;
      chk(req, stopped, 1'b0);
      chk(req, cpu_clk, 1'b1);
   endtask

   initial begin
      #400000;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
      $finish;
   end

   initial begin
      // R9: reset state
      repeat (3) @(posedge clk);
      #1 chk("R9", stopped, 1'b0);
      chk("R9", cpu_clk, 1'b1);
      rst = 1'b0;

      // R4 / R5 / R3 / R6: full sequence in both bus modes
      for (int m = 0; m < 2; m++) begin
         bus8 = m[0];
         bus_cyc(LPA, 1'b0, 3'b101);
         end_chk("R3", 1'b0);
         for (int i = 1; i <= m + 1; i++) begin
            bus_cyc(24'h000400 + 24'(i), 1'b1, 3'b110);
            end_chk(m == 0 ? "R4" : "R5", (i == m + 1));
         end
         if (m == 1) begin
            repeat (6) @(posedge clk);
            #1 chk("R11", stopped, 1'b1);
            chk("R11", cpu_clk, 1'b0);
         end
         do_restart("R8");
      end

      // R1: every other function code, and a read, never match
      bus8 = 1'b0;
      for (int f = 0; f < 8; f++) begin
         if (f != 5) begin
            bus_cyc(LPA, 1'b0, 3'(f));
            end_chk("R1", 1'b0);
            bus_cyc(24'h000100, 1'b1, 3'b110);
            end_chk("R1", 1'b0);
            do_restart("R1");
         end
      end
      bus_cyc(LPA, 1'b1, 3'b101);
      end_chk("R1", 1'b0);
      bus_cyc(24'h000100, 1'b1, 3'b110);
      end_chk("R1", 1'b0);

      // R2: each single address bit flipped prevents a match
      for (int b = 0; b < 24; b++) begin
         bus_cyc(LPA ^ (24'h1 << b), 1'b0, 3'b101);
         bus_cyc(24'h000200, 1'b1, 3'b110);
         end_chk("R2", 1'b0);
      end

      // R3: non-matching write then read keeps idle; a later match still works
      bus_cyc(24'h123456, 1'b0, 3'b101);
      bus_cyc(24'h000300, 1'b1, 3'b110);
      end_chk("R3", 1'b0);
      bus_cyc(LPA, 1'b0, 3'b101);
      bus_cyc(24'h000300, 1'b1, 3'b110);
      end_chk("R3", 1'b1);
      do_restart("R8");

      // R10: a second match mid-count counts as the fetch cycle
      bus_cyc(LPA, 1'b0, 3'b101);
      end_chk("R10", 1'b0);
      bus_cyc(LPA, 1'b0, 3'b101);
      end_chk("R10", 1'b1);
      do_restart("R8");

      // R8: restart in mid-count clears the count
      bus_cyc(LPA, 1'b0, 3'b101);
      do_restart("R8");
      bus_cyc(24'h000500, 1'b1, 3'b110);
      end_chk("R8", 1'b0);
      bus_cyc(24'h000504, 1'b1, 3'b110);
      end_chk("R8", 1'b0);

      // R9: asynchronous reset while stopped, applied in the low phase
      bus_cyc(LPA, 1'b0, 3'b101);
      bus_cyc(24'h000600, 1'b1, 3'b110);
      end_chk("R6", 1'b1);
      @(negedge clk); #0.5 rst = 1'b1;
      #0.1 chk("R9", stopped, 1'b0);
      @(posedge clk); #1 rst = 1'b0;
      chk("R9", cpu_clk, 1'b1);
      bus_cyc(24'h000604, 1'b1, 3'b110);
      end_chk("R9", 1'b0);

      // R7: no runt pulse seen anywhere
      chk("R7", (bad_pulses == 0), 1'b1);
      chk("R7", (pulses > 100), 1'b1);

      summary();
      $finish;
   end
endmodule